// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block sits between a PWM or motion controller and three separate power half-bridges. Each channel takes a requested high-side and a requested low-side command and turns them into two active-high gate enables that never overlap. A turn-on waits until the opposite switch of the same bridge has been off for a programmable dead time. A high-side turn-on also needs a charged bootstrap capacitor: the low-side switch must have been on long enough, and must have gone off recently enough. One shutdown input turns every gate off at once.

All intervals are counted in clock cycles. They are derived from a clock-frequency parameter (`CLK_MHZ`) and from nanosecond parameters: dead time 500 ns, minimum precharge 2000 ns and precharge validity 330000 ns by default. In the rest of this brief, D, P and W are those intervals in cycles (`CLK_MHZ*ns/1000`). A grounded-load bit for each channel waives the precharge rule. A status output for each channel shows whether a high-side turn-on would be accepted.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, every gate enable and every `hi_ready` bit is 0. The off-time counters start at zero, so no gate can turn on until D cycles after reset.
- R2: Within one channel, `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R3: When `shutdown` is 1, all six gate enables are 0 in that same cycle, whatever the commands are. The registered state clears as well.
- R4: A gate turns on one clock after its single command is present, but only once the opposite gate of the channel has been 0 for at least D consecutive cycles. This holds for both directions, so the minimum gap in which both are 0 is exactly D cycles.
- R5: When a command drops, its gate goes to 0 on the next clock.
- R6: A high-side turn-on needs a valid precharge. The low-side gate must have been 1 for at least P consecutive cycles: P-1 cycles is not enough and P is enough.
- R7: A precharge stays valid for W cycles after the low-side gate goes to 0. A high-side turn-on may happen on the W-th cycle after that fall and no later. After that, a new precharge is needed.
- R8: Once on, the high-side gate stays on for as long as its command stays, even past W cycles, with no forced refresh.
- R9: If both commands of a channel are 1, both gates of that channel are 0 on the next clock. A valid single command afterwards resumes normal operation.
- R10: With `gnd_load` set for a channel, the precharge rule is waived for it. Dead time still applies.
- R11: Asserting `shutdown` clears every channel's precharge. After release, a channel without a grounded load cannot turn on its high side until it precharges again.
- R12: `hi_ready` is 1 in a cycle exactly when a lone high-side request in that cycle would turn the high side on at the next clock. A blocked request is held off, not stored, and it takes effect on the first clock after `hi_ready` rises while it is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shutdown | input | 1 | Forces all gate enables off when 1 |
| cmd_hi | input | NCH | Requested high-side state, one bit per channel |
| cmd_lo | input | NCH | Requested low-side state, one bit per channel |
| gnd_load | input | NCH | Waives the precharge rule for a channel when 1 |
| gate_hi | output | NCH | High-side gate enable, active high |
| gate_lo | output | NCH | Low-side gate enable, active high |
| hi_ready | output | NCH | High-side turn-on currently permitted |

## Verification
The hardest cases to reach from the ports are the two edges of the bootstrap rule: a precharge one cycle too short, and a high-side request placed on the very last cycle before the precharge expires. To reach them, the bench runs the design with small cycle counts (D=10, P=20, W=100). It holds the low-side command for exactly P-1 and then exactly P cycles. It counts from the cycle in which the low-side gate falls, and places the high-side request so that the turn-on would land on cycle W of the validity window, then on a cycle beyond it. A shutdown pulse with high sides already on then shows that precharge state is lost across release on normal channels, while a grounded-load channel recovers at once.

// File: rtl/hb_pkg.sv
// Package: shared helpers for the half-bridge gate sequencer.
// Assumes time parameters are given in nanoseconds and the clock in MHz.
package hb_pkg;

    // Convert a duration in ns to a cycle count at the given clock (MHz).
    function automatic int ns_to_cyc(input int mhz, input int ns);
        int c;
        c = (mhz * ns) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/hb_offtimer.sv
// Module: hb_offtimer
// Counts consecutive cycles during which a gate has been off and flags when
// a LIMIT-cycle off interval has been completed by the end of this cycle.
// Assumes LIMIT >= 1; counter starts from zero after reset.
module hb_offtimer #(
    parameter int LIMIT = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic ok
);
    localparam int CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Restart on every on-cycle, saturate at LIMIT-1 while off.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (gate)       cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    assign ok = !gate && (cnt == TOP);
endmodule

// File: rtl/hb_bootstrap.sv
// Module: hb_bootstrap
// Tracks whether the bootstrap capacitor of one channel is charged: the
// low-side gate must stay on PRE consecutive cycles, and the charge is taken
// as valid for WIN cycles after the low side goes off. A clear input drops
// the charge at once. A waive input marks a grounded load.
// Assumes PRE >= 1 and WIN >= 1.
module hb_bootstrap #(
    parameter int PRE = 500,
    parameter int WIN = 82500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic lo_gate,
    input  logic waive,
    output logic ok
);
    localparam int PW = $clog2(PRE + 1);
    localparam int AW = $clog2(WIN + 1);
    localparam logic [PW-1:0] PTOP = PW'(PRE - 1);
    localparam logic [AW-1:0] ATOP = AW'(WIN - 1);

    logic [PW-1:0] on_cnt;
    logic [AW-1:0] age;
    logic          charged;

    // Length of the current low-side on interval, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              on_cnt <= '0;
        else if (!lo_gate)       on_cnt <= '0;
        else if (on_cnt != PTOP) on_cnt <= on_cnt + 1'b1;
    end

    // Cycles since the low side went off, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            age <= '0;
        else if (lo_gate)      age <= '0;
        else if (age != ATOP)  age <= age + 1'b1;
    end

    // Charge flag: set by a full precharge, cleared by expiry or shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n)                        charged <= 1'b0;
        else if (clear)                    charged <= 1'b0;
        else if (lo_gate && on_cnt == PTOP) charged <= 1'b1;
        else if (!lo_gate && age == ATOP)  charged <= 1'b0;
    end

    assign ok = waive || charged;
endmodule

// File: rtl/hb_leg.sv
// Module: hb_leg
// One half-bridge channel: resolves the two commands, applies dead time on
// each turn-on and the bootstrap rule on the high-side turn-on, and masks
// both gates with the shutdown input.
// Assumes commands are already synchronous to clk.
module hb_leg #(
    parameter int DEAD_CYC = 125,
    parameter int PRE_CYC  = 500,
    parameter int WIN_CYC  = 82500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sd,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic gnd_load,
    output logic gate_hi,
    output logic gate_lo,
    output logic hi_ready
);
    logic hi_q, lo_q;
    logic hi_off_ok, lo_off_ok, boot_ok;
    logic want_hi, want_lo, hi_perm, hi_nxt, lo_nxt;

    hb_offtimer #(.LIMIT(DEAD_CYC)) u_hi_off (
        .clk(clk), .rst_n(rst_n), .gate(hi_q), .ok(hi_off_ok)
    );

    hb_offtimer #(.LIMIT(DEAD_CYC)) u_lo_off (
        .clk(clk), .rst_n(rst_n), .gate(lo_q), .ok(lo_off_ok)
    );

    hb_bootstrap #(.PRE(PRE_CYC), .WIN(WIN_CYC)) u_boot (
        .clk(clk), .rst_n(rst_n), .clear(sd), .lo_gate(lo_q),
        .waive(gnd_load), .ok(boot_ok)
    );

    // Resolve requests; a conflicting pair means neither.
    always_comb begin
        want_hi = cmd_hi && !cmd_lo;
        want_lo = cmd_lo && !cmd_hi;
        hi_perm = lo_off_ok && boot_ok;
        hi_nxt  = want_hi && (hi_q || hi_perm);
        lo_nxt  = want_lo && (lo_q || hi_off_ok);
    end

    // Gate state registers, cleared by reset or shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n || sd) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_nxt;
            lo_q <= lo_nxt;
        end
    end

    assign gate_hi  = hi_q && !sd;
    assign gate_lo  = lo_q && !sd;
    assign hi_ready = hi_perm && !sd;
endmodule

// File: rtl/hb_gate_seq.sv
// Module: hb_gate_seq (top)
// Three (NCH) independent half-bridge channels sharing one shutdown input.
// Timing parameters are in ns and converted to cycles from CLK_MHZ.
// Assumes synchronous inputs and a synchronous active-low reset.
module hb_gate_seq #(
    parameter int NCH     = 3,
    parameter int CLK_MHZ = 250,
    parameter int DEAD_NS = 500,
    parameter int PRE_NS  = 2000,
    parameter int WIN_NS  = 330000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shutdown,
    input  logic [NCH-1:0] cmd_hi,
    input  logic [NCH-1:0] cmd_lo,
    input  logic [NCH-1:0] gnd_load,
    output logic [NCH-1:0] gate_hi,
    output logic [NCH-1:0] gate_lo,
    output logic [NCH-1:0] hi_ready
);
    localparam int DEAD_CYC = hb_pkg::ns_to_cyc(CLK_MHZ, DEAD_NS);
    localparam int PRE_CYC  = hb_pkg::ns_to_cyc(CLK_MHZ, PRE_NS);
    localparam int WIN_CYC  = hb_pkg::ns_to_cyc(CLK_MHZ, WIN_NS);

    // One sequencer per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        hb_leg #(
            .DEAD_CYC(DEAD_CYC), .PRE_CYC(PRE_CYC), .WIN_CYC(WIN_CYC)
        ) u_leg (
            .clk(clk), .rst_n(rst_n), .sd(shutdown),
            .cmd_hi(cmd_hi[i]), .cmd_lo(cmd_lo[i]), .gnd_load(gnd_load[i]),
            .gate_hi(gate_hi[i]), .gate_lo(gate_lo[i]), .hi_ready(hi_ready[i])
        );
    end
endmodule

// File: rtl/hb_gate_seq_chk.sv
// Module: hb_gate_seq_chk
// Property checker bound to hb_gate_seq. Keeps its own count of consecutive
// off cycles per gate to check the dead-time gap.
module hb_gate_seq_chk #(
    parameter int NCH     = 3,
    parameter int CLK_MHZ = 250,
    parameter int DEAD_NS = 500
) (
    input logic           clk,
    input logic           rst_n,
    input logic           shutdown,
    input logic [NCH-1:0] cmd_hi,
    input logic [NCH-1:0] cmd_lo,
    input logic [NCH-1:0] gate_hi,
    input logic [NCH-1:0] gate_lo,
    input logic [NCH-1:0] hi_ready
);
    localparam int DC = hb_pkg::ns_to_cyc(CLK_MHZ, DEAD_NS);
    localparam int RW = $clog2(DC + 1);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic [RW-1:0] run_hi, run_lo;

        // Consecutive off-cycle runs of each gate, saturating at DC.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_hi <= '0;
                run_lo <= '0;
            end else begin
                run_hi <= gate_hi[i] ? '0 : ((run_hi == RW'(DC)) ? run_hi : run_hi + 1'b1);
                run_lo <= gate_lo[i] ? '0 : ((run_lo == RW'(DC)) ? run_lo : run_lo + 1'b1);
            end
        end

        a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[i] && gate_lo[i]));
        a_r3_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
            shutdown |-> (!gate_hi[i] && !gate_lo[i]));
        a_r4_hi_dead: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[i]) |-> (run_lo == RW'(DC)));
        a_r4_lo_dead: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[i]) |-> (run_hi == RW'(DC)));
        a_r5_hi_release: assert property (@(posedge clk) disable iff (!rst_n)
            !cmd_hi[i] |=> !gate_hi[i]);
        a_r9_conflict: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_hi[i] && cmd_lo[i]) |=> (!gate_hi[i] && !gate_lo[i]));
        a_r12_ready_acts: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_hi[i] && !cmd_lo[i] && hi_ready[i]) |=> (gate_hi[i] || shutdown));
        a_r12_rise_permitted: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[i]) |-> $past(hi_ready[i]));
    end
endmodule

bind hb_gate_seq hb_gate_seq_chk #(
    .NCH(NCH), .CLK_MHZ(CLK_MHZ), .DEAD_NS(DEAD_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown),
    .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .hi_ready(hi_ready)
);

// File: tb/tb_hb_gate_seq.sv
// Scoreboard bench: the driver schedules expected output values by cycle,
// the monitor compares them at the falling edge. D=10, P=20, W=100 cycles.
module tb_hb_gate_seq;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           shutdown = 1'b0;
    logic [NCH-1:0] cmd_hi = '0;
    logic [NCH-1:0] cmd_lo = '0;
    logic [NCH-1:0] gnd_load = '0;
    logic [NCH-1:0] gate_hi, gate_lo, hi_ready;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    ch;
        int    fld;   // 0 gate_hi, 1 gate_lo, 2 hi_ready
        bit    val;
        string tag;
    } exp_t;

    exp_t sb[$];

    hb_gate_seq #(
        .NCH(NCH), .CLK_MHZ(250), .DEAD_NS(40), .PRE_NS(80), .WIN_NS(400)
    ) dut (
        .clk(clk), .rst_n(rst_n), .shutdown(shutdown),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .gnd_load(gnd_load),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .hi_ready(hi_ready)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int at, input int ch, input int fld,
                             input bit val, input string tag);
        exp_t e;
        e.at = at; e.ch = ch; e.fld = fld; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic go(input int n);
        while (cyc != n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: compare due items and check the overlap rule each cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                bit act;
                case (sb[i].fld)
                    0:       act = gate_hi[sb[i].ch];
                    1:       act = gate_lo[sb[i].ch];
                    default: act = hi_ready[sb[i].ch];
                endcase
                total++;
                if (act !== sb[i].val) begin
                    bad++;
                    $display("FAIL %s ch%0d fld%0d cyc%0d: actual=%0b expected=%0b",
                             sb[i].tag, sb[i].ch, sb[i].fld, cyc, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
        if (rst_n) begin
            total++;
            if ((gate_hi & gate_lo) != '0) begin
                bad++;
                $display("FAIL R2 overlap cyc%0d: actual=%b expected=000",
                         cyc, gate_hi & gate_lo);
            end
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            expect_at(3, c, 0, 0, "R1");
            expect_at(3, c, 1, 0, "R1");
            expect_at(3, c, 2, 0, "R1");
            expect_at(6, c, 2, 0, "R1");
        end
        go(5);
        rst_n = 1'b1;

        // R6: no precharge yet, high request blocked
        go(30);
        cmd_hi[0] = 1'b1;
        expect_at(33, 0, 0, 0, "R6");
        expect_at(33, 0, 2, 0, "R12");
        // precharge via low side
        go(40);
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b1;
        expect_at(41, 0, 1, 1, "R4");
        // low to high with dead time
        go(70);
        cmd_lo[0] = 1'b0; cmd_hi[0] = 1'b1;
        expect_at(71, 0, 1, 0, "R5");
        expect_at(79, 0, 2, 0, "R12");
        expect_at(80, 0, 2, 1, "R12");
        expect_at(80, 0, 0, 0, "R4");
        expect_at(81, 0, 0, 1, "R4");
        expect_at(270, 0, 0, 1, "R8");
        expect_at(270, 0, 2, 0, "R7");
        // high to low with dead time
        go(370);
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b1;
        expect_at(371, 0, 0, 0, "R5");
        expect_at(380, 0, 1, 0, "R4");
        expect_at(381, 0, 1, 1, "R4");
        // window expiry
        go(406);
        cmd_lo[0] = 1'b0;
        expect_at(407, 0, 1, 0, "R5");
        expect_at(506, 0, 2, 1, "R7");
        expect_at(507, 0, 2, 0, "R7");
        go(511);
        cmd_hi[0] = 1'b1;
        expect_at(526, 0, 0, 0, "R7");
        go(527);
        cmd_hi[0] = 1'b0;
        // fresh precharge, request on last valid cycle
        go(531);
        cmd_lo[0] = 1'b1;
        expect_at(532, 0, 1, 1, "R4");
        go(556);
        cmd_lo[0] = 1'b0;
        go(656);
        cmd_hi[0] = 1'b1;
        expect_at(656, 0, 0, 0, "R7");
        expect_at(657, 0, 0, 1, "R7");

        // channel 1: precharge one cycle short, then exact
        go(670);
        cmd_lo[1] = 1'b1;
        go(689);
        cmd_lo[1] = 1'b0; cmd_hi[1] = 1'b1;
        expect_at(710, 1, 0, 0, "R6");
        expect_at(710, 1, 2, 0, "R6");
        go(715);
        cmd_hi[1] = 1'b0; cmd_lo[1] = 1'b1;
        go(735);
        cmd_lo[1] = 1'b0; cmd_hi[1] = 1'b1;
        expect_at(745, 1, 0, 0, "R6");
        expect_at(746, 1, 0, 1, "R6");

        // channel 2: conflicting commands, then grounded load
        go(755);
        cmd_lo[2] = 1'b1;
        expect_at(756, 2, 1, 1, "R4");
        go(758);
        cmd_hi[2] = 1'b1;
        expect_at(759, 2, 1, 0, "R9");
        expect_at(759, 2, 0, 0, "R9");
        expect_at(761, 2, 0, 0, "R9");
        go(763);
        cmd_hi[2] = 1'b0; gnd_load[2] = 1'b1;
        expect_at(764, 2, 1, 1, "R9");
        go(767);
        cmd_lo[2] = 1'b0; cmd_hi[2] = 1'b1;
        expect_at(777, 2, 0, 0, "R10");
        expect_at(778, 2, 0, 1, "R10");

        // shutdown with all high sides on
        for (int c = 0; c < NCH; c++) expect_at(789, c, 0, 1, "R3");
        go(790);
        shutdown = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            expect_at(790, c, 0, 0, "R3");
            expect_at(790, c, 2, 0, "R3");
        end
        go(795);
        shutdown = 1'b0;
        expect_at(795, 2, 0, 0, "R10");
        expect_at(796, 2, 0, 1, "R10");
        expect_at(810, 0, 0, 0, "R11");
        expect_at(810, 1, 0, 0, "R11");
        expect_at(810, 0, 2, 0, "R11");

        go(820);
        foreach (sb[i]) begin
            total++;
            bad++;
            $display("FAIL %s never compared: actual=none expected=%0b", sb[i].tag, sb[i].val);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule